// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block keeps the slot control word and the slot status word of a hot-plug capable downstream or root port. It also tracks whether a card is present and whether its link is up, and it decides when the port interrupts. A configuration write port carries a 32-bit word. The low half is the control word and the high half is the status word, and each half has its own write strobe. Side inputs report that a card was inserted, that the attention button was pressed, and that the port is being reset.

Every write to the control half is one command, and that command completes in the same cycle. The block computes one pending level from the enabled events. It notifies software only when that level changes. With message interrupts enabled it pulses a request for one cycle; otherwise a level interrupt output follows the pending level. When software turns the slot power and the power indicator off while a card is present, the block pulses a detach strobe toward the secondary bus and reports that presence has changed.

Top module: `hpslot_ctrl`

## Requirements
- R1: After `rst` the control word reads 0x07C0 (both indicators off, power off, all enables 0), the status word reads 0 and all outputs are low. This assumes `HAS_PWR_CTL`=1.
- R2: Status bits 0 (button pressed), 3 (presence changed) and 4 (command completed) are write-one-to-clear. Writes to status bits 6 (present), 7 (locked) and 8 (link up) have no effect.
- R3: The pending level is control bit 5 (interrupt enable) ANDed with the OR over bits 0, 3 and 4 of status AND control. Nothing is signalled while bit 5 is 0.
- R4: A notification happens only when the pending level differs from the last notified level. If `msi_en` is set, `msg_req` pulses for one cycle. If not, `irq_level` takes the new pending level.
- R5: Raising an event whose status bits are all already set causes no notification.
- R6: Any write to the control half is applied, and status bit 4 is then set in the same cycle.
- R7: Writing 1 to control bit 11 toggles status bit 7. Control bit 11 always reads 0.
- R8: A control write with bit 10 = 1 and bits 9:8 = 11, made while status bit 6 is set, pulses `detach`. It also clears status bits 6 and 8 and sets status bit 3.
- R9: `insert_req` sets status bits 6 and 8 and raises bits 0 and 3 together. While status bit 7 is set, the insertion is refused: `insert_err` pulses and status is unchanged.
- R10: `button_req` raises status bit 0.
- R11: `port_rst` clears the enables, lock bit and events, leaving only bits 6 and 8 of status, and drops `irq_level`. The attention indicator is set off. The power indicator and power control are set as follows: occupied gives control word 0x01C0 (on, powered); empty gives 0x07C0.
- R12: Indicator fields are at control bits 7:6 (attention) and 9:8 (power), coded 01 on, 10 blink, 11 off. Writing 00 to a field leaves it unchanged.
- R13: A status write re-evaluates the pending level without sending a message. If `msi_en` is clear and nothing is pending, `irq_level` drops.
- R14: The order inside one cycle is: status clear, control command, command-completed event, insertion, button. `port_rst` overrides all other inputs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| port_rst | input | 1 | Port reset request (slot reset behaviour) |
| msi_en | input | 1 | Message interrupts enabled |
| cfg_wr_ctl | input | 1 | Write strobe for the control half |
| cfg_wr_sts | input | 1 | Write strobe for the status half |
| cfg_wdata | input | 32 | Write data: [15:0] control, [31:16] status |
| cfg_rdata | output | 32 | Read data: [15:0] control, [31:16] status |
| insert_req | input | 1 | A card was inserted |
| button_req | input | 1 | Attention button pressed |
| irq_level | output | 1 | Level interrupt |
| msg_req | output | 1 | One-cycle message interrupt request |
| detach | output | 1 | One-cycle strobe to detach the secondary-bus devices |
| insert_err | output | 1 | One-cycle flag: insertion refused, slot locked |

## Verification
The delicate overlap is a single 32-bit write that both clears command-completed through the status half and issues a command through the control half. The bench drives such a write and expects bit 4 still set afterwards, because the completion of the new command comes after the clear. A second overlap is a port reset arriving with an insertion and a button press in the same cycle. Here the bench expects the reset pattern and no new events. A behavioural model runs alongside on every clock and settles the other orderings, including a detach or lock toggle followed by an insertion.

// File: rtl/hpslot_pkg.sv
`timescale 1ns/1ps
package hpslot_pkg;
    typedef logic [15:0] word_t;

    typedef enum logic [1:0] {
        IND_KEEP  = 2'b00,
        IND_ON    = 2'b01,
        IND_BLINK = 2'b10,
        IND_OFF   = 2'b11
    } ind_e;

    // control word bit positions
    localparam int C_BTN_IE   = 0;
    localparam int C_PDC_IE   = 3;
    localparam int C_CC_IE    = 4;
    localparam int C_HP_IE    = 5;
    localparam int C_ATT_LO   = 6;
    localparam int C_PWR_LO   = 8;
    localparam int C_PWR_OFF  = 10;
    localparam int C_LOCK_TGL = 11;

    // status word bit positions
    localparam int S_BTN     = 0;
    localparam int S_PDC     = 3;
    localparam int S_CC      = 4;
    localparam int S_PRESENT = 6;
    localparam int S_LOCKED  = 7;
    localparam int S_LINK    = 8;

    localparam word_t EVT_MASK  = word_t'((1 << S_BTN) | (1 << S_PDC) | (1 << S_CC));
    localparam word_t PRES_LINK = word_t'((1 << S_PRESENT) | (1 << S_LINK));
    localparam int    N_STAGES  = 4;

    function automatic logic pending_of(word_t c, word_t s);
        return c[C_HP_IE] && (|(c & s & EVT_MASK));
    endfunction

    function automatic ind_e ind_merge(ind_e cur, logic [1:0] wr);
        return (wr == 2'b00) ? cur : ind_e'(wr);
    endfunction

    function automatic word_t stage_mask(int k);
        case (k)
            1:       return word_t'(1 << S_CC);
            2:       return word_t'((1 << S_BTN) | (1 << S_PDC));
            3:       return word_t'(1 << S_BTN);
            default: return '0;
        endcase
    endfunction

    function automatic word_t reset_ctl(logic occupied, logic has_pwr);
        word_t c;
        c = '0;
        c[C_ATT_LO +: 2] = IND_OFF;
        if (has_pwr) begin
            c[C_PWR_LO +: 2] = occupied ? IND_ON : IND_OFF;
            c[C_PWR_OFF]     = !occupied;
        end
        return c;
    endfunction
endpackage

// File: rtl/hpslot_evt_stage.sv
`timescale 1ns/1ps
module hpslot_evt_stage
    import hpslot_pkg::*;
#(
    parameter word_t MASK       = '0,
    parameter bit    FORCE_EVAL = 1'b0
) (
    input  logic  en,
    input  logic  msi_en,
    input  word_t ctl,
    input  word_t sts_i,
    input  logic  notified_i,
    input  logic  irq_i,
    output word_t sts_o,
    output logic  notified_o,
    output logic  irq_o,
    output logic  changed_o
);
    logic fresh, eval, pend;

    always_comb begin
        fresh      = |(MASK & ~sts_i);
        sts_o      = en ? (sts_i | MASK) : sts_i;
        eval       = en && (FORCE_EVAL || fresh);
        pend       = pending_of(ctl, sts_o);
        changed_o  = eval && (pend != notified_i);
        notified_o = eval ? pend : notified_i;
        irq_o      = (changed_o && !msi_en) ? pend : irq_i;
    end
endmodule

// File: rtl/hpslot_cmd_dec.sv
`timescale 1ns/1ps
module hpslot_cmd_dec
    import hpslot_pkg::*;
#(
    parameter bit HAS_PWR_CTL = 1'b1
) (
    input  word_t cur,
    input  word_t wr,
    output word_t nxt
);
    localparam int N_IND = 2;
    ind_e ind_n [N_IND];
    logic unused_wr;

    assign unused_wr = ^{wr[15:12], wr[2:1], cur[15:10], cur[5:0]};

    for (genvar i = 0; i < N_IND; i++) begin : g_ind
        localparam int LO = (i == 0) ? C_ATT_LO : C_PWR_LO;
        assign ind_n[i] = ind_merge(ind_e'(cur[LO +: 2]), wr[LO +: 2]);
    end

    always_comb begin
        nxt                  = '0;
        nxt[C_BTN_IE]        = wr[C_BTN_IE];
        nxt[C_PDC_IE]        = wr[C_PDC_IE];
        nxt[C_CC_IE]         = wr[C_CC_IE];
        nxt[C_HP_IE]         = wr[C_HP_IE];
        nxt[C_ATT_LO +: 2]   = ind_n[0];
        nxt[C_PWR_LO +: 2]   = ind_n[1];
        nxt[C_PWR_OFF]       = HAS_PWR_CTL ? wr[C_PWR_OFF] : 1'b0;
        nxt[C_LOCK_TGL]      = 1'b0;
    end
endmodule

// File: rtl/hpslot_ctrl.sv
`timescale 1ns/1ps
module hpslot_ctrl
    import hpslot_pkg::*;
#(
    parameter bit HAS_PWR_CTL = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        port_rst,
    input  logic        msi_en,
    input  logic        cfg_wr_ctl,
    input  logic        cfg_wr_sts,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        insert_req,
    input  logic        button_req,
    output logic        irq_level,
    output logic        msg_req,
    output logic        detach,
    output logic        insert_err
);
    word_t ctl_q, sts_q;
    logic  notified_q, irq_q, msg_q, det_q, err_q;

    word_t ctl_w, ctl_a, sts_a;
    logic  notif_a, irq_a, det_a, ins_ok, ins_err;
    word_t wr_ctl_d, wr_sts_d;

    word_t sin  [N_STAGES];
    word_t sout [N_STAGES];
    logic  nin  [N_STAGES];
    logic  nout [N_STAGES];
    logic  iin  [N_STAGES];
    logic  iout [N_STAGES];
    logic [N_STAGES-1:0] st_en, st_chg;

    assign wr_ctl_d = cfg_wdata[15:0];
    assign wr_sts_d = cfg_wdata[31:16];

    hpslot_cmd_dec #(.HAS_PWR_CTL(HAS_PWR_CTL)) u_dec (
        .cur (ctl_q),
        .wr  (wr_ctl_d),
        .nxt (ctl_w)
    );

    // status clear, control command, lock toggle and detach
    always_comb begin
        ctl_a   = cfg_wr_ctl ? ctl_w : ctl_q;
        sts_a   = sts_q;
        notif_a = notified_q;
        irq_a   = irq_q;
        if (cfg_wr_sts) begin
            sts_a   = sts_a & ~(wr_sts_d & EVT_MASK);
            notif_a = pending_of(ctl_a, sts_a);
            if (!msi_en && !notif_a) irq_a = 1'b0;
        end
        if (cfg_wr_ctl && wr_ctl_d[C_LOCK_TGL])
            sts_a[S_LOCKED] = !sts_a[S_LOCKED];
        det_a = cfg_wr_ctl && sts_q[S_PRESENT] && wr_ctl_d[C_PWR_OFF]
                && (wr_ctl_d[C_PWR_LO +: 2] == IND_OFF);
        if (det_a) begin
            sts_a[S_PRESENT] = 1'b0;
            sts_a[S_LINK]    = 1'b0;
            sts_a[S_PDC]     = 1'b1;
        end
        ins_ok  = insert_req && !sts_a[S_LOCKED];
        ins_err = insert_req &&  sts_a[S_LOCKED];
    end

    assign st_en = {button_req, ins_ok, cfg_wr_ctl, cfg_wr_ctl};

    // chain of event stages: re-evaluate, command done, insertion, button
    always_comb begin
        sin[0] = sts_a;
        nin[0] = notif_a;
        iin[0] = irq_a;
        for (int k = 1; k < N_STAGES; k++) begin
            sin[k] = sout[k-1];
            nin[k] = nout[k-1];
            iin[k] = iout[k-1];
        end
        if (ins_ok) sin[2] = sout[1] | PRES_LINK;
    end

    for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
        hpslot_evt_stage #(
            .MASK       (stage_mask(k)),
            .FORCE_EVAL (k == 0)
        ) u_stage (
            .en         (st_en[k]),
            .msi_en     (msi_en),
            .ctl        (ctl_a),
            .sts_i      (sin[k]),
            .notified_i (nin[k]),
            .irq_i      (iin[k]),
            .sts_o      (sout[k]),
            .notified_o (nout[k]),
            .irq_o      (iout[k]),
            .changed_o  (st_chg[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q      <= reset_ctl(1'b0, HAS_PWR_CTL);
            sts_q      <= '0;
            notified_q <= 1'b0;
            irq_q      <= 1'b0;
            msg_q      <= 1'b0;
            det_q      <= 1'b0;
            err_q      <= 1'b0;
        end else if (port_rst) begin
            ctl_q      <= reset_ctl(sts_q[S_PRESENT], HAS_PWR_CTL);
            sts_q      <= sts_q & PRES_LINK;
            notified_q <= 1'b0;
            irq_q      <= 1'b0;
            msg_q      <= 1'b0;
            det_q      <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            ctl_q      <= ctl_a;
            sts_q      <= sout[N_STAGES-1];
            notified_q <= nout[N_STAGES-1];
            irq_q      <= iout[N_STAGES-1];
            msg_q      <= msi_en && (|st_chg);
            det_q      <= det_a;
            err_q      <= ins_err;
        end
    end

    assign cfg_rdata  = {sts_q, ctl_q};
    assign irq_level  = irq_q;
    assign msg_req    = msg_q;
    assign detach     = det_q;
    assign insert_err = err_q;
endmodule

// File: rtl/hpslot_ctrl_chk.sv
`timescale 1ns/1ps
module hpslot_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        port_rst,
    input logic        msi_en,
    input logic        cfg_wr_ctl,
    input logic        insert_req,
    input logic        irq_level,
    input logic        msg_req,
    input logic        detach,
    input logic        insert_err,
    input logic [15:0] ctl_q,
    input logic [15:0] sts_q
);
    p_msg_needs_msi_r4: assert property (@(posedge clk) disable iff (rst)
        msg_req |-> $past(msi_en));

    p_cmd_done_r6: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_wr_ctl && !port_rst && !rst) |-> sts_q[4]);

    p_detach_effect_r8: assert property (@(posedge clk) disable iff (rst)
        detach |-> (sts_q[3] && ($past(insert_req) || (!sts_q[6] && !sts_q[8]))));

    p_refused_insert_r9: assert property (@(posedge clk) disable iff (rst)
        insert_err |-> ($past(insert_req) && sts_q[7]));

    p_port_reset_r11: assert property (@(posedge clk) disable iff (rst)
        $past(port_rst && !rst) |-> (!irq_level && !msg_req && !detach
            && (ctl_q[5:0] == 6'b0) && (ctl_q[7:6] == 2'b11)));

    p_att_ind_coded_r12: assert property (@(posedge clk) disable iff (rst)
        ctl_q[7:6] != 2'b00);
endmodule

bind hpslot_ctrl hpslot_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .port_rst   (port_rst),
    .msi_en     (msi_en),
    .cfg_wr_ctl (cfg_wr_ctl),
    .insert_req (insert_req),
    .irq_level  (irq_level),
    .msg_req    (msg_req),
    .detach     (detach),
    .insert_err (insert_err),
    .ctl_q      (ctl_q),
    .sts_q      (sts_q)
);

// File: tb/hpslot_ctrl_test.sv
`timescale 1ns/1ps
module hpslot_ctrl_test;
    localparam bit HAS_PWR = 1'b1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        port_rst = 1'b0, msi_en = 1'b0;
    logic        cfg_wr_ctl = 1'b0, cfg_wr_sts = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        insert_req = 1'b0, button_req = 1'b0;
    logic        irq_level, msg_req, detach, insert_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    logic [15:0] m_ctl, m_sts;
    bit m_not, m_irq, m_msg, m_det, m_err;

    always #2 clk = ~clk;

    hpslot_ctrl #(.HAS_PWR_CTL(HAS_PWR)) uut (
        .clk(clk), .rst(rst), .port_rst(port_rst), .msi_en(msi_en),
        .cfg_wr_ctl(cfg_wr_ctl), .cfg_wr_sts(cfg_wr_sts),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .insert_req(insert_req), .button_req(button_req),
        .irq_level(irq_level), .msg_req(msg_req),
        .detach(detach), .insert_err(insert_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic bit m_pend();
        return m_ctl[5] && ((m_sts[0] && m_ctl[0]) || (m_sts[3] && m_ctl[3]) || (m_sts[4] && m_ctl[4]));
    endfunction

    task automatic m_raise(input logic [15:0] bits, input bit always_eval);
        bit p;
        if (!always_eval && ((bits & ~m_sts) == 16'h0)) return;
        m_sts = m_sts | bits;
        p = m_pend();
        if (p != m_not) begin
            m_not = p;
            if (msi_en) m_msg = 1'b1;
            else        m_irq = p;
        end
    endtask

    task automatic m_reset(input bit occ);
        m_ctl = 16'h00C0;
        if (HAS_PWR) m_ctl = m_ctl | (occ ? 16'h0100 : 16'h0700);
        m_sts = m_sts & 16'h0140;
        m_not = 0; m_irq = 0; m_msg = 0; m_det = 0; m_err = 0;
    endtask

    task automatic m_step();
        logic [15:0] wc, ws;
        bit occ_before;
        wc = cfg_wdata[15:0];
        ws = cfg_wdata[31:16];
        if (rst) begin m_sts = 0; m_reset(0); return; end
        if (port_rst) begin m_reset(m_sts[6]); return; end
        m_msg = 0; m_det = 0; m_err = 0;
        occ_before = m_sts[6];
        if (cfg_wr_ctl) begin
            logic [15:0] n;
            n = 16'h0;
            n[0] = wc[0]; n[3] = wc[3]; n[4] = wc[4]; n[5] = wc[5];
            n[7:6] = (wc[7:6] == 2'b00) ? m_ctl[7:6] : wc[7:6];
            n[9:8] = (wc[9:8] == 2'b00) ? m_ctl[9:8] : wc[9:8];
            n[10]  = HAS_PWR ? wc[10] : 1'b0;
            m_ctl = n;
        end
        if (cfg_wr_sts) begin
            m_sts = m_sts & ~(ws & 16'h0019);
            m_not = m_pend();
            if (!msi_en && !m_not) m_irq = 0;
        end
        if (cfg_wr_ctl) begin
            if (wc[11]) m_sts[7] = ~m_sts[7];
            if (occ_before && wc[10] && wc[9:8] == 2'b11) begin
                m_det = 1;
                m_sts[6] = 0; m_sts[8] = 0; m_sts[3] = 1;
            end
            m_raise(16'h0000, 1'b1);
            m_raise(16'h0010, 1'b0);
        end
        if (insert_req) begin
            if (m_sts[7]) m_err = 1;
            else begin
                m_sts = m_sts | 16'h0140;
                m_raise(16'h0009, 1'b0);
            end
        end
        if (button_req) m_raise(16'h0001, 1'b0);
    endtask

    task automatic compare_all();
        chk("R12 ctl", {16'h0, cfg_rdata[15:0]}, {16'h0, m_ctl});
        chk("R2 sts", {16'h0, cfg_rdata[31:16]}, {16'h0, m_sts});
        chk("R3 irq", {31'h0, irq_level}, {31'h0, m_irq});
        chk("R4 msg", {31'h0, msg_req}, {31'h0, m_msg});
        chk("R8 detach", {31'h0, detach}, {31'h0, m_det});
        chk("R9 err", {31'h0, insert_err}, {31'h0, m_err});
    endtask

    task automatic tick(input bit wc, input bit ws, input logic [31:0] wd,
                        input bit ins, input bit btn, input bit pr);
        cfg_wr_ctl = wc; cfg_wr_sts = ws; cfg_wdata = wd;
        insert_req = ins; button_req = btn; port_rst = pr;
        @(posedge clk);
        m_step();
        @(negedge clk);
        compare_all();
        cfg_wr_ctl = 0; cfg_wr_sts = 0; cfg_wdata = '0;
        insert_req = 0; button_req = 0; port_rst = 0;
    endtask

    task automatic idle();
        tick(0, 0, 32'h0, 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R1 act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_sts = 0; m_reset(0);
        @(negedge clk);
        rst = 1'b1;
        repeat (3) idle();
        rst = 1'b0;
        idle();
        // R1 reset state
        chk("R1 ctl", cfg_rdata, 32'h0000_07C0);
        chk("R1 irq", {31'h0, irq_level}, 32'h0);

        // R6 command completes, R3 irq follows pending, R12 00 ignored
        tick(1, 0, 32'h0000_0039, 0, 0, 0);
        chk("R6 cc", cfg_rdata, 32'h0010_03F9);
        chk("R3 irq on", {31'h0, irq_level}, 32'h1);
        // R13 clear drops level
        tick(0, 1, 32'h0010_0000, 0, 0, 0);
        chk("R13 irq off", {31'h0, irq_level}, 32'h0);
        // R3 no interrupt without global enable
        tick(1, 0, 32'h0000_0019, 0, 0, 0);
        chk("R3 no hpie", {31'h0, irq_level}, 32'h0);
        tick(1, 0, 32'h0000_0039, 0, 0, 0);
        chk("R3 hpie", {31'h0, irq_level}, 32'h1);
        tick(0, 1, 32'h0010_0000, 0, 0, 0);

        // R9 insertion
        tick(0, 0, 32'h0, 1, 0, 0);
        chk("R9 insert", {16'h0, cfg_rdata[31:16]}, 32'h0000_0149);
        chk("R9 irq", {31'h0, irq_level}, 32'h1);
        // R2 W1C with read-only bits
        tick(0, 1, 32'h01C9_0000, 0, 0, 0);
        chk("R2 w1c", {16'h0, cfg_rdata[31:16]}, 32'h0000_0140);

        // message mode: R10, R4, R5, R13
        msi_en = 1'b1;
        tick(0, 0, 32'h0, 0, 1, 0);
        chk("R10 button", {16'h0, cfg_rdata[31:16]}, 32'h0000_0141);
        chk("R4 msg pulse", {31'h0, msg_req}, 32'h1);
        idle();
        chk("R4 msg single", {31'h0, msg_req}, 32'h0);
        tick(0, 0, 32'h0, 0, 1, 0);
        chk("R5 no dup", {31'h0, msg_req}, 32'h0);
        tick(0, 1, 32'h0001_0000, 0, 0, 0);
        chk("R13 no msg", {31'h0, msg_req}, 32'h0);

        // R12 indicators
        tick(1, 0, 32'h0000_0279, 0, 0, 0);
        chk("R12 enc", {16'h0, cfg_rdata[15:0]}, 32'h0000_0279);
        tick(1, 0, 32'h0000_0039, 0, 0, 0);
        chk("R12 keep", {16'h0, cfg_rdata[15:0]}, 32'h0000_0279);

        // R7 lock toggle, R9 refused
        tick(1, 0, 32'h0000_0839, 0, 0, 0);
        chk("R7 locked", cfg_rdata, 32'h01D0_0279);
        tick(0, 0, 32'h0, 1, 0, 0);
        chk("R9 refused", {31'h0, insert_err}, 32'h1);
        chk("R9 unchanged", {16'h0, cfg_rdata[31:16]}, 32'h0000_01D0);
        tick(1, 0, 32'h0000_0839, 0, 0, 0);
        chk("R7 unlocked", {16'h0, cfg_rdata[31:16]}, 32'h0000_0150);

        // R8 detach
        tick(1, 0, 32'h0000_07F9, 0, 0, 0);
        chk("R8 strobe", {31'h0, detach}, 32'h1);
        chk("R8 sts", {16'h0, cfg_rdata[31:16]}, 32'h0000_0018);
        tick(1, 0, 32'h0000_07F9, 0, 0, 0);
        chk("R8 empty", {31'h0, detach}, 32'h0);

        // R14 combined write: clear first, completion after
        msi_en = 1'b0;
        tick(1, 1, 32'h0010_0039, 0, 0, 0);
        chk("R14 cc kept", {31'h0, cfg_rdata[20]}, 32'h1);

        // R11 / R14 port reset overrides insert and button
        tick(0, 0, 32'h0, 1, 0, 0);
        tick(0, 0, 32'h0, 1, 1, 1);
        chk("R11 occupied", cfg_rdata, 32'h0140_01C0);
        chk("R14 reset wins", {31'h0, irq_level}, 32'h0);
        tick(1, 0, 32'h0000_07F9, 0, 0, 0);
        tick(0, 0, 32'h0, 0, 0, 1);
        chk("R11 empty", cfg_rdata, 32'h0000_07C0);
        repeat (3) idle();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule